// File: doc/BRIEF.md
# Bridge Protection and Fault Supervisor

This block supervises a power half-bridge output stage. It samples an overcurrent flag, an undervoltage flag and an unsigned junction-temperature code in degrees Celsius. From these it produces three things: an active-low early thermal warning, an active-low latched fault indication, and a single disable line that forces the bridge decode into the high-impedance state. Thermal shutdown uses separate trip and release thresholds. The warning uses a lower threshold of its own and never disables the bridge.

Once an overcurrent or thermal trip has been latched, it is cleared in one of two ways, chosen by a mode input:
- **Latched mode.** The output-enable line must go high, then low, then high again.
- **Auto-retry mode.** The fault is released after a fixed number of clocks, but only if no trip source is active when that count runs out. Otherwise the count starts over.

Undervoltage, a low sleep input and a low output-enable input all disable the bridge without latching anything. After reset the bridge also stays disabled until sleep and output-enable have both been seen high at a clock edge. A small register keeps the source of the most recent event.

Top module: `bridge_guard_top`

## Requirements
- R1: `warn_n_o` is low in the cycle after a clock edge at which `temp_code_i` > WARN_C (default 130). It is high after an edge at which the code is at or below WARN_C.
- R2: The thermal trip source turns on at an edge where `temp_code_i` >= SHUT_C (150). It stays on while the code is above SHUT_C-HYST_C (125) and turns off at an edge where the code is at or below 125.
- R3: A clock edge that samples `oc_flag_i` high, or the thermal source on, drives `fault_n_o` low after that edge. `bridge_off_o` is high whenever `fault_n_o` is low.
- R4: With `auto_mode_i`=0, the fault stays latched until `oe_i` is sampled high, then low, then high while latched. It clears after that final edge, provided no trip is present there. A trip at that edge cancels the sequence.
- R5: With `auto_mode_i`=1, `fault_n_o` stays low for exactly RETRY_CYC cycles after it falls, and then rises if no trip is sampled at the expiry edge. If a trip is sampled there, a further full RETRY_CYC period follows.
- R6: `bridge_off_o` is high from the cycle after `uv_flag_i` is sampled high until the cycle after it is sampled low. Undervoltage never changes `fault_n_o`.
- R7: `bridge_off_o` is high in any cycle where `sleep_n_i` or `oe_i` is low. This path is combinational.
- R8: After reset, `bridge_off_o` stays high until a clock edge samples both `sleep_n_i` and `oe_i` high.
- R9: `cause_o` codes are 2'b01 overcurrent, 2'b10 thermal and 2'b11 undervoltage. The register is loaded when the fault latches, with overcurrent preferred over thermal. Otherwise it is loaded on an undervoltage rising edge. It holds its value in between.
- R10: During and straight after reset, `warn_n_o`=1, `fault_n_o`=1, `bridge_off_o`=1 and `cause_o`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_flag_i | input | 1 | Overcurrent detected |
| uv_flag_i | input | 1 | Supply below lockout level |
| temp_code_i | input | TEMP_W | Junction temperature, unsigned °C |
| sleep_n_i | input | 1 | Low selects low-power sleep (bridge off) |
| oe_i | input | 1 | Output enable; low forces Hi-Z; also drives the latched-mode clear sequence |
| auto_mode_i | input | 1 | 1 selects timed auto-retry, 0 selects latched shutdown |
| warn_n_o | output | 1 | Thermal warning, active low |
| fault_n_o | output | 1 | Latched fault, active low |
| bridge_off_o | output | 1 | Disable to bridge decode (all switches off) |
| cause_o | output | 2 | Source of the most recent event |

## Verification
Two events can land on the same edge. First, the retry count can expire, or the output-enable re-raise that would clear the latch can arrive, on the very edge where a trip is sampled. Second, an overcurrent and a thermal trip can latch together while an undervoltage edge arrives. The bench drives these on purpose: it holds the overcurrent flag across the expiry edge, raises `oe_i` while the temperature is still inside the hysteresis band, and raises overcurrent together with a 150 °C code. It judges each against a cycle model that expects the fault to stay latched and the overcurrent cause to win. Random traffic with sparse trips and a drifting temperature then revisits these coincidences many times.

// File: rtl/bg_pkg.sv
package bg_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OC   = 2'b01,
    CAUSE_HOT  = 2'b10,
    CAUSE_UV   = 2'b11
  } cause_e;

  // Next state of the thermal trip with separate set and release levels
  function automatic logic hot_step(input logic hot_now, input int temp,
                                    input int set_lvl, input int rel_lvl);
    return hot_now ? (temp > rel_lvl) : (temp >= set_lvl);
  endfunction

  // Cause recorded when the latch sets; overcurrent wins a tie
  function automatic cause_e trip_cause(input logic oc);
    return oc ? CAUSE_OC : CAUSE_HOT;
  endfunction

endpackage

// File: rtl/bg_thermal.sv
module bg_thermal import bg_pkg::*; #(
  parameter int TEMP_W = 8,
  parameter int WARN_C = 130,
  parameter int SHUT_C = 150,
  parameter int HYST_C = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o,
  output logic              hot_nx_o,
  output logic              warn_o
);
  localparam int REL_C = SHUT_C - HYST_C;

  logic hot_q, warn_q;

  assign hot_nx_o = hot_step(hot_q, int'(temp_i), SHUT_C, REL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      hot_q  <= hot_nx_o;
      warn_q <= int'(temp_i) > WARN_C;
    end
  end

  assign hot_o  = hot_q;
  assign warn_o = warn_q;
endmodule

// File: rtl/bg_fault_latch.sv
module bg_fault_latch #(
  parameter int RETRY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic auto_i,
  input  logic oe_i,
  output logic flt_o,
  output logic expire_o,
  output logic clear_o
);
  localparam int CNT_W = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_CYC - 1);

  logic             flt_q, armed_q, oe_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seq_done;

  assign expire_o = flt_q & auto_i & (cnt_q == LAST);
  assign seq_done = flt_q & ~auto_i & armed_q & oe_i;
  assign clear_o  = ~trip_i & (expire_o | seq_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q   <= 1'b0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      oe_q <= oe_i;
      if (trip_i)       flt_q <= 1'b1;
      else if (clear_o) flt_q <= 1'b0;

      if (!flt_q || !auto_i || expire_o) cnt_q <= '0;
      else                               cnt_q <= cnt_q + CNT_W'(1);

      if (!flt_q || auto_i)        armed_q <= 1'b0;
      else if (armed_q && oe_i)    armed_q <= 1'b0;
      else if (oe_q && !oe_i)      armed_q <= 1'b1;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/bg_enable_gate.sv
module bg_enable_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_i,
  input  logic oe_i,
  input  logic uv_i,
  input  logic flt_i,
  output logic uv_rise_o,
  output logic off_o
);
  logic uv_q, ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      uv_q    <= uv_i;
      ready_q <= ready_q | (sleep_n_i & oe_i);
    end
  end

  assign uv_rise_o = uv_i & ~uv_q;
  assign off_o     = ~ready_q | flt_i | uv_q | ~sleep_n_i | ~oe_i;
endmodule

// File: rtl/bridge_guard_top.sv
module bridge_guard_top import bg_pkg::*; #(
  parameter int TEMP_W    = 8,
  parameter int WARN_C    = 130,
  parameter int SHUT_C    = 150,
  parameter int HYST_C    = 25,
  parameter int RETRY_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_flag_i,
  input  logic              uv_flag_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              sleep_n_i,
  input  logic              oe_i,
  input  logic              auto_mode_i,
  output logic              warn_n_o,
  output logic              fault_n_o,
  output logic              bridge_off_o,
  output logic [1:0]        cause_o
);
  logic   hot_w, hot_nx_w, warn_w;
  logic   trip_w, flt_w, expire_w, clear_w;
  logic   uv_rise_w, latch_set_w;
  cause_e cause_q;

  bg_thermal #(.TEMP_W(TEMP_W), .WARN_C(WARN_C), .SHUT_C(SHUT_C), .HYST_C(HYST_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_code_i),
    .hot_o(hot_w), .hot_nx_o(hot_nx_w), .warn_o(warn_w)
  );

  assign trip_w      = oc_flag_i | hot_nx_w;
  assign latch_set_w = trip_w & ~flt_w;

  bg_fault_latch #(.RETRY_CYC(RETRY_CYC)) u_latch (
    .clk(clk), .rst_n(rst_n), .trip_i(trip_w), .auto_i(auto_mode_i), .oe_i(oe_i),
    .flt_o(flt_w), .expire_o(expire_w), .clear_o(clear_w)
  );

  bg_enable_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n_i), .oe_i(oe_i),
    .uv_i(uv_flag_i), .flt_i(flt_w), .uv_rise_o(uv_rise_w), .off_o(bridge_off_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cause_q <= CAUSE_NONE;
    else if (latch_set_w) cause_q <= trip_cause(oc_flag_i);
    else if (uv_rise_w)   cause_q <= CAUSE_UV;
  end

  assign cause_o   = cause_q;
  assign warn_n_o  = ~warn_w;
  assign fault_n_o = ~flt_w;
endmodule

// File: rtl/bg_guard_chk.sv
module bg_guard_chk #(
  parameter int TEMP_W = 8,
  parameter int WARN_C = 130,
  parameter int SHUT_C = 150
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic              sleep_n_i,
  input logic              oe_i,
  input logic              auto_mode_i,
  input logic              warn_n_o,
  input logic              fault_n_o,
  input logic              bridge_off_o,
  input logic [1:0]        cause_o,
  input logic              trip_w,
  input logic              hot_w,
  input logic              expire_w,
  input logic              clear_w
);
  // R1
  warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp_code_i) > WARN_C) |=> !warn_n_o);

  // R2
  hot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_w) |-> ($past(int'(temp_code_i)) >= SHUT_C));

  // R3
  trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_w |=> !fault_n_o);

  // R3
  off_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> bridge_off_o);

  // R4
  shut_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_n_o) && !$past(auto_mode_i)) |-> ($past(oe_i) && !$past(trip_w)));

  // R5
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_n_o) && $past(auto_mode_i)) |-> $past(expire_w));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |=> fault_n_o);

  // R7
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n_i || !oe_i) |-> bridge_off_o);

  // R9
  cause_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n_o) |-> (cause_o == 2'b01 || cause_o == 2'b10));
endmodule

bind bridge_guard_top bg_guard_chk #(.TEMP_W(TEMP_W), .WARN_C(WARN_C), .SHUT_C(SHUT_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_code_i(temp_code_i), .sleep_n_i(sleep_n_i),
  .oe_i(oe_i), .auto_mode_i(auto_mode_i), .warn_n_o(warn_n_o), .fault_n_o(fault_n_o),
  .bridge_off_o(bridge_off_o), .cause_o(cause_o), .trip_w(trip_w), .hot_w(hot_w),
  .expire_w(expire_w), .clear_w(clear_w)
);

// File: tb/tb_bridge_guard_top.sv
module tb_bridge_guard_top;
  localparam int CLK_T = 10;
  localparam int R_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc = 1'b0, uv = 1'b0, sl = 1'b0, oe = 1'b0, am = 1'b0;
  logic [7:0] tc = 8'd25;
  logic warn_n, fault_n, off;
  logic [1:0] cause;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_hot, m_warn, m_flt, m_arm, m_oeq, m_uvq, m_ready;
  int m_cnt, m_cause;

  always #(CLK_T/2) clk = ~clk;

  bridge_guard_top #(.RETRY_CYC(R_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .oc_flag_i(oc), .uv_flag_i(uv), .temp_code_i(tc),
    .sleep_n_i(sl), .oe_i(oe), .auto_mode_i(am), .warn_n_o(warn_n),
    .fault_n_o(fault_n), .bridge_off_o(off), .cause_o(cause)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit hot_rule(bit was, int t);
    if (t >= 150) return 1;
    if (t <= 125) return 0;
    return was;
  endfunction

  function automatic int exp_off();
    return (!m_ready || m_flt || m_uvq || !sl || !oe) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_hot = 0; m_warn = 0; m_flt = 0; m_arm = 0; m_oeq = 0;
    m_uvq = 0; m_ready = 0; m_cnt = 0; m_cause = 0;
  endtask

  task automatic model_edge();
    bit h, trip, fire, nf, narm;
    int ncnt;
    h = hot_rule(m_hot, int'(tc));
    trip = oc | h;
    if (!m_flt && trip) m_cause = oc ? 1 : 2;
    else if (uv && !m_uvq) m_cause = 3;
    nf = m_flt; ncnt = 0; narm = 0;
    if (m_flt && am) begin
      fire = (m_cnt == R_CYC - 1);
      ncnt = fire ? 0 : m_cnt + 1;
      if (fire && !trip) nf = 0;
    end
    if (m_flt && !am) begin
      if (m_arm && oe) begin
        narm = 0;
        if (!trip) nf = 0;
      end else narm = m_arm | (m_oeq & !oe);
    end
    if (trip) nf = 1;
    m_flt = nf; m_cnt = ncnt; m_arm = narm;
    m_hot = h;
    m_warn = int'(tc) > 130;
    m_oeq = oe; m_uvq = uv;
    m_ready = m_ready | (sl & oe);
  endtask

  task automatic step(bit i_oc, bit i_uv, int t, bit i_sl, bit i_oe, bit i_am, string tag);
    @(negedge clk);
    oc = i_oc; uv = i_uv; tc = 8'(t); sl = i_sl; oe = i_oe; am = i_am;
    @(posedge clk);
    model_edge();
    #1;
    chk("R1", "warn_n", int'(warn_n), m_warn ? 0 : 1);
    chk(tag, "fault_n", int'(fault_n), m_flt ? 0 : 1);
    chk(tag == "R3" ? "R7" : tag, "bridge_off", int'(off), exp_off());
    chk("R9", "cause", int'(cause), m_cause);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lowc;
    int t;
    bit a;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", "warn_n", int'(warn_n), 1);
    chk("R10", "fault_n", int'(fault_n), 1);
    chk("R10", "bridge_off", int'(off), 1);
    chk("R10", "cause", int'(cause), 0);
    @(negedge clk); rst_n = 1'b1;

    // R8 startup gating: oe low keeps bridge off
    for (int i = 0; i < 4; i++) step(0, 0, 25, 1, 0, 0, "R8");
    chk("R8", "off before enable", int'(off), 1);
    step(0, 0, 25, 1, 1, 0, "R8");
    chk("R8", "off after enable edge", int'(off), 0);

    // R1 warning threshold
    step(0, 0, 130, 1, 1, 0, "R1");
    chk("R1", "warn at 130", int'(warn_n), 1);
    step(0, 0, 131, 1, 1, 0, "R1");
    chk("R1", "warn at 131", int'(warn_n), 0);

    // R2 thermal trip with hysteresis, latched mode
    step(0, 0, 149, 1, 1, 0, "R2");
    chk("R2", "no trip at 149", int'(fault_n), 1);
    step(0, 0, 150, 1, 1, 0, "R2");
    chk("R2", "trip at 150", int'(fault_n), 0);
    chk("R9", "thermal cause", int'(cause), 2);
    step(0, 0, 140, 1, 1, 0, "R2");
    step(0, 0, 140, 1, 0, 0, "R2");
    step(0, 0, 126, 1, 1, 0, "R2");   // re-raise inside band: trip still on
    chk("R2", "latched at 126", int'(fault_n), 0);
    step(0, 0, 125, 1, 1, 0, "R2");
    step(0, 0, 125, 1, 0, 0, "R4");
    step(0, 0, 100, 1, 1, 0, "R4");
    chk("R4", "cleared after sequence", int'(fault_n), 1);

    // R4 overcurrent while oe already low: low-high alone must not clear
    step(0, 0, 60, 1, 0, 0, "R4");
    step(1, 0, 60, 1, 0, 0, "R4");
    chk("R9", "oc cause", int'(cause), 1);
    step(0, 0, 60, 1, 1, 0, "R4");
    for (int i = 0; i < 20; i++) step(0, 0, 60, 1, 1, 0, "R4");
    chk("R4", "held without sequence", int'(fault_n), 0);
    step(0, 0, 60, 1, 0, 0, "R4");
    step(0, 0, 60, 1, 1, 0, "R4");
    chk("R4", "cleared by high-low-high", int'(fault_n), 1);

    // R5 auto retry, single pulse
    step(1, 0, 60, 1, 1, 1, "R5");
    lowc = 0;
    for (int i = 0; i < 3 * R_CYC; i++) begin
      step(0, 0, 60, 1, 1, 1, "R5");
      if (!fault_n) lowc++;
    end
    chk("R5", "low cycles single", lowc + 1, R_CYC);
    // R5 trip persists across expiry
    step(1, 0, 60, 1, 1, 1, "R5");
    lowc = 0;
    for (int i = 0; i < 4 * R_CYC; i++) begin
      step(i < R_CYC + 2 ? 1 : 0, 0, 60, 1, 1, 1, "R5");
      if (!fault_n) lowc++;
    end
    chk("R5", "low cycles persistent", lowc + 1, 2 * R_CYC);

    // R6 undervoltage lockout
    step(0, 1, 60, 1, 1, 0, "R6");
    chk("R6", "off under uv", int'(off), 1);
    chk("R6", "fault untouched", int'(fault_n), 1);
    chk("R9", "uv cause", int'(cause), 3);
    step(0, 0, 60, 1, 1, 0, "R6");
    chk("R6", "off recovers", int'(off), 0);

    // R7 sleep forces off immediately
    step(0, 0, 60, 0, 1, 0, "R7");
    chk("R7", "sleep off", int'(off), 1);

    // R9 overcurrent and thermal on the same edge
    step(1, 0, 150, 1, 1, 0, "R9");
    chk("R9", "tie prefers oc", int'(cause), 1);
    step(0, 0, 100, 1, 1, 0, "R4");
    step(0, 0, 100, 1, 0, 0, "R4");
    step(0, 0, 100, 1, 1, 0, "R4");

    // random mix
    t = 100; a = 0;
    for (int i = 0; i < 6000; i++) begin
      if (i % 700 == 0) a = ~a;
      t = t + int'($urandom % 11) - 5;
      if (t < 0) t = 0;
      if (t > 200) t = 200;
      step(($urandom % 40) == 0, ($urandom % 50) == 0, t,
           ($urandom % 80) != 0, ($urandom % 12) != 0, a, "R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule